// File: doc/BRIEF.md
# Tick Compare Soft-Interrupt Unit

This unit keeps a 17-bit software-interrupt pending register and a 64-bit tick compare register for one processor thread. It compares both against a free-running 63-bit tick count that arrives on an input port. When the low 63 bits of the compare register equal the count and the compare register's top bit is clear, pending bit 16 is set. The unit drives a level interrupt request whenever global interrupt enable is on and some pending bit has a level above the thread's current priority.

Software reaches the pending register at three addresses. One replaces the register's contents, one only sets bits and one only clears bits. A read-modify-write is therefore never needed to post or acknowledge a single source. The compare register has an address of its own. The top bit of the compare register masks the match and is not part of the compared value. Reset sets that bit, so the compare is disabled until software arms it.

Top module: `tick_softint_unit`

## Requirements
- R1: A write to address 1 (set alias) ORs wr_data[16:0] into the pending register. Pending bits whose data bit is 0 keep their value.
- R2: A write to address 2 (clear alias) clears every pending bit whose wr_data bit is 1. The other pending bits keep their value.
- R3: A write to address 0 replaces the pending register with wr_data[16:0]. wr_data[63:17] has no effect. The new value is visible on rd_data one clock edge after the write.
- R4: If tick_cnt equals compare bits [62:0] at a clock edge and compare bit 63 is 0, pending bit 16 is set at that edge.
- R5: While compare bit 63 is 1, an equal count changes no pending bit and raises no request.
- R6: irq is 1 exactly when int_en is 1 and some set pending bit has a level above pri_lvl. Bits 1 to 15 have level 1 to 15. Bits 0 and 16 have level 14.
- R7: irq follows int_en and pri_lvl combinationally. When int_en rises or pri_lvl drops, the request appears in the same cycle, with no clock edge in between.
- R8: The pending register is read at addresses 0, 1 and 2, zero-extended to 64 bits. The compare register is written and read at address 3. Both read back exactly the value stored.
- R9: A match fires once per equality episode. If the count stays equal to the compare value, pending bit 16 is not set again after software clears it, until equality is lost and found again.
- R10: Synchronous active-high reset clears the pending register and loads the compare register with only bit 63 set.
- R11: When a match fires in the same cycle as a pending write, the write is applied first and bit 16 is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 direct, 1 set alias, 2 clear alias, 3 compare |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 64 | Combinational read data |
| tick_cnt | input | 63 | Free-running tick count |
| int_en | input | 1 | Global interrupt enable |
| pri_lvl | input | 4 | Current processor priority level |
| irq | output | 1 | Level interrupt request |

## Verification
Register writes and count matches take effect at the clock edge where they are presented, and their effect is visible on rd_data right after that edge. The bench drives every input at the falling edge and reads back one falling edge later, so exactly one rising edge falls between stimulus and check. irq depends combinationally on the stored pending value, int_en and pri_lvl. The enable and priority sweeps therefore change those inputs and sample a nanosecond later, with no clock edge in between, which also shows that the re-evaluation happens in the same cycle.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int DATA_W   = 64;
    localparam int TICK_W   = 63;
    localparam int PEND_W   = 17;
    localparam int LVL_W    = 4;
    localparam int ADDR_W   = 2;
    localparam int MATCH_BIT = PEND_W - 1;
    localparam int EDGE_LVL  = 14;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DIRECT = 2'd0,
        ADR_SET    = 2'd1,
        ADR_CLEAR  = 2'd2,
        ADR_CMP    = 2'd3
    } tsu_addr_e;

    typedef struct packed {
        logic              en;
        tsu_addr_e         addr;
        logic [DATA_W-1:0] data;
    } tsu_wr_t;

    // Priority level of pending bit idx: outer bits share a fixed level.
    function automatic int level_of(input int idx);
        if (idx == 0 || idx == MATCH_BIT)
            return EDGE_LVL;
        return idx;
    endfunction

endpackage

// File: rtl/tsu_pending_reg.sv
module tsu_pending_reg
    import tsu_pkg::*;
#(
    parameter int P_W = PEND_W,
    parameter int M_BIT = MATCH_BIT
) (
    input  logic           clk,
    input  logic           rst,
    input  tsu_wr_t        req,
    input  logic           fire,
    output logic [P_W-1:0] pend_q
);

    logic [P_W-1:0] wr_val;
    logic [P_W-1:0] after_wr;
    logic [P_W-1:0] match_mask;

    assign wr_val = req.data[P_W-1:0];

    always_comb begin
        after_wr = pend_q;
        if (req.en) begin
            unique case (req.addr)
                ADR_DIRECT: after_wr = wr_val;
                ADR_SET:    after_wr = pend_q | wr_val;
                ADR_CLEAR:  after_wr = pend_q & ~wr_val;
                default:    after_wr = pend_q;
            endcase
        end
    end

    always_comb begin
        match_mask = '0;
        match_mask[M_BIT] = fire;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= after_wr | match_mask;
    end

    AST_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.addr == ADR_SET) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R1

    AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.addr == ADR_CLEAR && !fire) |=> ((pend_q & $past(wr_val)) == '0)); // R2

    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        fire |=> pend_q[M_BIT]); // R4

endmodule

// File: rtl/tsu_cmp_match.sv
module tsu_cmp_match
    import tsu_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int T_W = TICK_W
) (
    input  logic           clk,
    input  logic           rst,
    input  tsu_wr_t        req,
    input  logic [T_W-1:0] tick_cnt,
    output logic [D_W-1:0] cmp_q,
    output logic           fire
);

    localparam int DIS_BIT = D_W - 1;

    logic equal_now;
    logic armed_eq;
    logic armed_eq_q;

    assign equal_now = (tick_cnt == cmp_q[T_W-1:0]);
    assign armed_eq  = equal_now && !cmp_q[DIS_BIT];
    assign fire      = armed_eq && !armed_eq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q      <= '0;
            cmp_q[DIS_BIT] <= 1'b1;
            armed_eq_q <= 1'b0;
        end else begin
            armed_eq_q <= armed_eq;
            if (req.en && req.addr == ADR_CMP)
                cmp_q <= req.data[D_W-1:0];
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmp_q[DIS_BIT] |-> !fire); // R5

    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
        (fire && !(req.en && req.addr == ADR_CMP)) |=> !fire); // R9

endmodule

// File: rtl/tsu_irq_eval.sv
module tsu_irq_eval
    import tsu_pkg::*;
#(
    parameter int P_W = PEND_W,
    parameter int L_W = LVL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] pend,
    input  logic           int_en,
    input  logic [L_W-1:0] pri_lvl,
    output logic           irq
);

    logic [P_W-1:0] hit;

    for (genvar i = 0; i < P_W; i++) begin : g_lvl
        localparam int LVL = level_of(i);
        assign hit[i] = pend[i] && (LVL > int'(pri_lvl));
    end

    assign irq = int_en && (|hit);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq); // R6

    AST_TOP_BIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (int_en && pend[P_W-1] && int'(pri_lvl) < EDGE_LVL) |-> irq); // R6

    AST_NOTHING_PENDING: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq); // R6

endmodule

// File: rtl/tick_softint_unit.sv
module tick_softint_unit
    import tsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TICK_W-1:0] tick_cnt,
    input  logic              int_en,
    input  logic [LVL_W-1:0]  pri_lvl,
    output logic              irq
);

    tsu_wr_t           req;
    logic [PEND_W-1:0] pend_q;
    logic [DATA_W-1:0] cmp_q;
    logic              fire;

    assign req.en   = wr_en;
    assign req.addr = tsu_addr_e'(wr_addr);
    assign req.data = wr_data;

    tsu_cmp_match #(.D_W(DATA_W), .T_W(TICK_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .tick_cnt (tick_cnt),
        .cmp_q    (cmp_q),
        .fire     (fire)
    );

    tsu_pending_reg #(.P_W(PEND_W), .M_BIT(MATCH_BIT)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .fire   (fire),
        .pend_q (pend_q)
    );

    tsu_irq_eval #(.P_W(PEND_W), .L_W(LVL_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend_q),
        .int_en  (int_en),
        .pri_lvl (pri_lvl),
        .irq     (irq)
    );

    always_comb begin
        if (tsu_addr_e'(rd_addr) == ADR_CMP)
            rd_data = cmp_q;
        else
            rd_data = {{(DATA_W-PEND_W){1'b0}}, pend_q};
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == '0 && cmp_q == {1'b1, {(DATA_W-1){1'b0}}})); // R10

    AST_MASKED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmp_q[DATA_W-1] && !wr_en) |=> (pend_q == $past(pend_q))); // R5

endmodule

// File: tb/tick_softint_unit_tb_top.sv
module tick_softint_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [63:0] rd_data;
    logic [62:0] tick_cnt = '0;
    logic        int_en = 1'b0;
    logic [3:0]  pri_lvl = 4'd15;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tick_softint_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_cnt(tick_cnt), .int_en(int_en), .pri_lvl(pri_lvl), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Write presented at a falling edge, taken at the following rising edge.
    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [63:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    function automatic int lvl(input int b);
        return (b == 0 || b == 16) ? 14 : b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [16:0] exp_p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        rd_check(2'd0, 64'd0, "R10 pending after reset");
        rd_check(2'd3, 64'h8000_0000_0000_0000, "R10 compare after reset");

        // R3 direct write, upper bits ignored
        wr(2'd0, 64'hFFFF_FFFF_FFFE_A5A5);
        exp_p = 17'h0A5A5;
        rd_check(2'd0, {47'd0, exp_p}, "R3 direct write");
        rd_check(2'd1, {47'd0, exp_p}, "R8 read at set alias");
        rd_check(2'd2, {47'd0, exp_p}, "R8 read at clear alias");

        // R1 set alias
        wr(2'd1, 64'h0001_0F00);
        exp_p = exp_p | 17'h10F00;
        rd_check(2'd0, {47'd0, exp_p}, "R1 set alias");
        // R2 clear alias
        wr(2'd2, 64'h0000_00FF);
        exp_p = exp_p & ~17'h000FF;
        rd_check(2'd0, {47'd0, exp_p}, "R2 clear alias");
        wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_check(2'd0, 64'd0, "R2 clear all");

        // R8 compare readback exact
        wr(2'd3, 64'hC123_4567_89AB_CDEF);
        rd_check(2'd3, 64'hC123_4567_89AB_CDEF, "R8 compare readback");

        // R6 near-exhaustive sweep: each single pending bit, priority, enable
        for (int b = 0; b < 17; b++) begin
            wr(2'd0, 64'd1 << b);
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 2; e++) begin
                    int_en = e[0]; pri_lvl = p[3:0];
                    #1;
                    check(irq == ((e == 1) && (lvl(b) > p)), $sformatf("R6 bit%0d pri%0d en%0d", b, p, e),
                          {63'd0, irq}, {63'd0, (e == 1) && (lvl(b) > p)});
                end
            end
        end

        // R7 same-cycle response to enable rise and priority drop
        wr(2'd0, 64'h20);
        @(negedge clk);
        int_en = 1'b0; pri_lvl = 4'd3; #1;
        check(irq == 1'b0, "R7 disabled", {63'd0, irq}, 64'd0);
        int_en = 1'b1; #1;
        check(irq == 1'b1, "R7 enable rise", {63'd0, irq}, 64'd1);
        pri_lvl = 4'd7; #1;
        check(irq == 1'b0, "R7 high priority masks", {63'd0, irq}, 64'd0);
        pri_lvl = 4'd2; #1;
        check(irq == 1'b1, "R7 priority drop", {63'd0, irq}, 64'd1);
        wr(2'd0, 64'd0);

        // R5 masked compare
        pri_lvl = 4'd0; int_en = 1'b1;
        wr(2'd3, 64'h8000_0000_0000_00C8);
        tick_cnt = 63'd200;
        repeat (3) @(negedge clk);
        rd_check(2'd0, 64'd0, "R5 masked no pending");
        check(irq == 1'b0, "R5 masked no irq", {63'd0, irq}, 64'd0);

        // R4 armed match while counting
        tick_cnt = 63'd90;
        wr(2'd3, 64'd100);
        for (int t = 91; t < 100; t++) begin
            @(negedge clk); tick_cnt = 63'(t);
        end
        @(negedge clk);
        rd_check(2'd0, 64'd0, "R4 no match before equal");
        tick_cnt = 63'd100;
        @(negedge clk);
        rd_check(2'd0, 64'h10000, "R4 match sets bit16");
        check(irq == 1'b1, "R4 match raises irq", {63'd0, irq}, 64'd1);

        // R9 held equal: cleared bit stays clear
        wr(2'd2, 64'h10000);
        repeat (3) @(negedge clk);
        rd_check(2'd0, 64'd0, "R9 no refire while held");

        // R11 match and clear-alias write in the same cycle
        tick_cnt = 63'd99;
        @(negedge clk);
        tick_cnt = 63'd100;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 64'h10001;
        @(negedge clk);
        wr_en = 1'b0;
        rd_check(2'd0, 64'h10000, "R11 match wins over clear");

        // R9 re-arm after leaving equality fires again
        wr(2'd0, 64'd0);
        tick_cnt = 63'd101;
        @(negedge clk);
        tick_cnt = 63'd100;
        @(negedge clk);
        rd_check(2'd0, 64'h10000, "R9 refire after new equality");

        // R10 reset again restores state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_check(2'd0, 64'd0, "R10 pending after second reset");
        rd_check(2'd3, 64'h8000_0000_0000_0000, "R10 compare after second reset");

        finish_run();
    end

endmodule